// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns a stream of bytes into asynchronous serial characters. Bytes come in over a valid/ready interface and wait in a FIFO whose depth is a parameter (8 to 256, a power of two). A frame engine takes each byte out of the FIFO and sends it on `txd`. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. Bit timing comes from a 16x tick. An internal 16-bit divisor sets how often that tick fires.

The character length, the parity kind and the stop length are plain control inputs. Each frame takes the values present on them when its start bit begins. When automatic clear-to-send is enabled, a high (deasserted) `cts_n` stops any new frame from starting. A frame that has already begun always runs to its end. Two status outputs report an empty FIFO and an idle line.

Back-pressure on the input works as follows. A byte is accepted on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low only while the FIFO is full. A sender that sees `in_ready` low keeps `in_valid` and `in_data` steady until a handshake happens.

Top module: `uart_tx_fc`

## Requirements
- R1: Bytes are accepted on edges where `in_valid` and `in_ready` are both high, and are sent in the order they were accepted. `in_ready` is low exactly when `FIFO_DEPTH` bytes are held and not yet taken.
- R2: The idle line is high. Each frame starts with one low start bit, followed by the data bits with the least significant bit first. `char_len` 2'b00, 01, 10 and 11 select 5, 6, 7 and 8 data bits.
- R3: `parity_mode` 2'b01 appends an odd parity bit and 2'b10 appends an even parity bit, in both cases right after the last data bit. With 2'b00 or 2'b11 no parity bit is sent. The parity is computed over the transmitted data bits only.
- R4: With `stop_long`=0 the stop period is 16 ticks. With `stop_long`=1 it is 24 ticks when the character length is 5 bits, and 32 ticks for any other length.
- R5: A tick occurs once every `divisor` clocks, and a `divisor` of 0 behaves as 1. Every start, data and parity bit lasts exactly 16 ticks.
- R6: With `auto_cts_en`=1 and `cts_n`=1, no new start bit begins. A frame already in progress completes normally.
- R7: With `auto_cts_en`=0, `cts_n` has no effect on transmission.
- R8: `fifo_empty` is high when the FIFO holds no byte. `tx_idle` is high when no frame is in progress, which includes the whole time after reset.
- R9: If another byte is waiting and allowed to go when a stop period ends, its start bit follows immediately with no extra idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | FIFO can accept a byte |
| in_data | input | 8 | Input byte |
| divisor | input | 16 | Clocks per 16x tick (0 treated as 1) |
| char_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_mode | input | 2 | 00/11 none, 01 odd, 10 even |
| stop_long | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| auto_cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| fifo_empty | output | 1 | FIFO holds no byte |
| tx_idle | output | 1 | No frame in progress |

## Verification
The bench decodes `txd` at mid-bit and measures the stop period in clocks between frames sent back to back. Two faults show up this way: a stop period cut short or stretched by a tick, and an idle gap inserted between frames. The bench fills the FIFO to the last slot and expects `in_ready` to drop at that point. A flag that goes off by one would accept a lost byte or refuse a legal one. It also raises `cts_n` part-way through a frame. A design that gates on the line instead of at the frame boundary would truncate that frame, and one that ignores the gate would start the next frame too early. Divisor 0, the 1.5-stop case at 5 bits, and both parity senses over random masked data show whether the tick count, the stop length or the parity sense is wrong.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  localparam logic [1:0] PAR_ODD  = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;

  localparam int unsigned TICKS_PER_BIT = 16;

  function automatic logic [7:0] char_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;

  assign last_cnt = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick     = (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R5: with a divisor above one, two ticks never fall on adjacent clocks
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last_cnt != '0) |=> (!tick || !$stable(divisor)));
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign rdata   = mem[rptr_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R1: the frame engine only takes a byte that exists
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R1: occupancy never passes the depth
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       can_start,
  input  logic [7:0] fifo_data,
  input  logic [1:0] char_len,
  input  logic [1:0] parity_mode,
  input  logic       stop_long,
  output logic       pop,
  output logic       txd,
  output logic       busy
);
  tx_state_e  st_q;
  logic [4:0] tcnt_q;
  logic [7:0] sh_q;
  logic [2:0] bit_q, last_idx_q;
  logic       par_q, par_en_q, long_q;
  logic [4:0] last_tick;
  logic       bit_end, load;
  logic [7:0] masked;

  assign masked = fifo_data & char_mask(char_len);

  always_comb begin
    last_tick = 5'd15;
    if (st_q == ST_STOP && long_q)
      last_tick = (last_idx_q == 3'd4) ? 5'd23 : 5'd31;
  end

  assign bit_end = tick && (tcnt_q == last_tick);
  assign load    = tick && can_start &&
                   (st_q == ST_IDLE || (st_q == ST_STOP && bit_end));
  assign pop     = load;
  assign busy    = (st_q != ST_IDLE);

  always_comb begin
    case (st_q)
      ST_START:  txd = 1'b0;
      ST_DATA:   txd = sh_q[0];
      ST_PARITY: txd = par_q;
      default:   txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      tcnt_q     <= '0;
      sh_q       <= '0;
      bit_q      <= '0;
      last_idx_q <= '0;
      par_q      <= 1'b0;
      par_en_q   <= 1'b0;
      long_q     <= 1'b0;
    end else if (tick) begin
      if (load) begin
        st_q       <= ST_START;
        tcnt_q     <= '0;
        sh_q       <= masked;
        last_idx_q <= 3'd4 + 3'(char_len);
        par_q      <= (^masked) ^ (parity_mode == PAR_ODD);
        par_en_q   <= (parity_mode == PAR_ODD) || (parity_mode == PAR_EVEN);
        long_q     <= stop_long;
      end else if (bit_end) begin
        tcnt_q <= '0;
        case (st_q)
          ST_START: begin
            st_q  <= ST_DATA;
            bit_q <= '0;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if (bit_q == last_idx_q) st_q <= par_en_q ? ST_PARITY : ST_STOP;
            else                     bit_q <= bit_q + 1'b1;
          end
          ST_PARITY: st_q <= ST_STOP;
          default:   st_q <= ST_IDLE;
        endcase
      end else if (st_q != ST_IDLE) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R5: without a tick nothing in the frame moves
  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(st_q) && $stable(tcnt_q)));
  // R9: a byte is taken only at a frame boundary
  p_pop_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (st_q == ST_IDLE || st_q == ST_STOP));
  // R2: every accepted byte opens with a start bit
  p_pop_starts_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (st_q == ST_START && !txd));
endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic [1:0]       parity_mode,
  input  logic             stop_long,
  input  logic             auto_cts_en,
  input  logic             cts_n,
  output logic             txd,
  output logic             fifo_empty,
  output logic             tx_idle
);
  logic       tick, full, pop, busy, can_start;
  logic [7:0] head;

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .wdata(in_data),
    .pop(pop), .rdata(head), .full(full), .empty(fifo_empty)
  );

  assign can_start = !fifo_empty && (!auto_cts_en || !cts_n);

  uart_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .can_start(can_start),
    .fifo_data(head), .char_len(char_len), .parity_mode(parity_mode),
    .stop_long(stop_long), .pop(pop), .txd(txd), .busy(busy)
  );

  assign in_ready = !full;
  assign tx_idle  = !busy;

  // R6: an idle line stays idle while the gate is closed
  p_cts_holds_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && cts_n && tx_idle) |=> tx_idle);
  // R2: the line is high whenever no frame is running
  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);
  // R8: nothing leaves an empty FIFO
  p_empty_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && tx_idle) |=> tx_idle);
endmodule

// File: tb/uart_tx_fc_bench.sv
module uart_tx_fc_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  char_len = 2'b11;
  logic [1:0]  parity_mode = 2'b00;
  logic        stop_long = 1'b0;
  logic        auto_cts_en = 1'b1;
  logic        cts_n = 1'b1;
  logic        txd, fifo_empty, tx_idle;

  int total = 0;
  int bad = 0;
  bit start_pending = 0;

  always #2.5 clk = ~clk;

  uart_tx_fc #(.FIFO_DEPTH(DEPTH)) u_uart_tx_fc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .divisor(divisor), .char_len(char_len),
    .parity_mode(parity_mode), .stop_long(stop_long),
    .auto_cts_en(auto_cts_en), .cts_n(cts_n), .txd(txd),
    .fifo_empty(fifo_empty), .tx_idle(tx_idle)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic bit has_par(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input int n, input logic [1:0] m);
    logic [7:0] md;
    md = d & 8'((1 << n) - 1);
    return (^md) ^ (m == 2'b01);
  endfunction

  function automatic int exp_stop(input int n, input bit lng, input int dv);
    return (lng ? ((n == 5) ? 24 : 32) : 16) * dv;
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rx_frame(input int n, input bit hp, input int bt, input int limit,
                          output logic [7:0] d, output logic p, output logic sb, output int stopc);
    int g;
    d = '0;
    p = 1'b0;
    if (!start_pending) begin
      g = 0;
      do begin
        @(negedge clk);
        g++;
      end while (txd !== 1'b0 && g < 60000);
    end
    start_pending = 0;
    repeat (bt / 2) @(negedge clk);
    sb = txd;
    for (int i = 0; i < n; i++) begin
      repeat (bt) @(negedge clk);
      d[i] = txd;
    end
    if (hp) begin
      repeat (bt) @(negedge clk);
      p = txd;
    end
    repeat (bt - bt / 2) @(negedge clk);
    stopc = 0;
    while (txd === 1'b1 && stopc < limit) begin
      @(negedge clk);
      stopc++;
    end
    if (txd === 1'b0) start_pending = 1;
  endtask

  task automatic run_case(input logic [1:0] len, input logic [1:0] pm, input bit lng,
                          input int dv, input int nbytes, input bit auto_mode);
    logic [7:0] q[$];
    logic [7:0] b, d;
    logic p, sb;
    int n, bt, es, stopc;
    n  = 5 + int'(len);
    bt = 16 * eff_div(dv);
    es = exp_stop(n, lng, eff_div(dv));
    @(negedge clk);
    auto_cts_en = 1'b1;
    cts_n       = 1'b1;
    char_len    = len;
    parity_mode = pm;
    stop_long   = lng;
    divisor     = 16'(dv);
    start_pending = 0;
    for (int i = 0; i < nbytes; i++) begin
      b = 8'($urandom);
      q.push_back(b);
      push(b);
    end
    repeat (3 * bt) @(negedge clk);
    check("R6", "idle while gated", tx_idle, 1);
    check("R8", "fifo_empty after pushes", fifo_empty, 0);
    if (nbytes == DEPTH) check("R1", "in_ready when full", in_ready, 0);
    if (auto_mode) cts_n = 1'b0;
    else begin
      auto_cts_en = 1'b0;
      cts_n       = 1'b1;   // R7: ignored with gating off
    end
    for (int i = 0; i < nbytes; i++) begin
      rx_frame(n, has_par(pm), bt, es + 2 * bt, d, p, sb, stopc);
      check("R2", "start bit", sb, 0);
      check("R2", "data bits", d, q[i] & 8'((1 << n) - 1));
      if (has_par(pm)) check("R3", "parity bit", p, exp_par(q[i], n, pm));
      if (i < nbytes - 1) check("R9", "stop length back to back (R4)", stopc, es);
      else                check("R4", "final stop and idle", stopc, es + 2 * bt);
    end
    check("R8", "tx_idle at end", tx_idle, 1);
    check("R8", "fifo_empty at end", fifo_empty, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic p, sb;
    int stopc;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "reset tx_idle", tx_idle, 1);
    check("R8", "reset fifo_empty", fifo_empty, 1);
    check("R2", "reset line high", txd, 1);
    check("R1", "reset in_ready", in_ready, 1);

    run_case(2'b11, 2'b00, 1'b0, 1, 4, 1'b1);     // 8N1
    run_case(2'b00, 2'b10, 1'b1, 2, 3, 1'b1);     // 5E1.5 (R4)
    run_case(2'b10, 2'b01, 1'b1, 1, 3, 1'b1);     // 7O2
    run_case(2'b01, 2'b00, 1'b0, 0, 2, 1'b1);     // divisor 0 as 1 (R5)
    run_case(2'b11, 2'b11, 1'b0, 1, 2, 1'b0);     // gating off (R7)
    run_case(2'b11, 2'b00, 1'b0, 1, DEPTH, 1'b1); // full FIFO (R1)

    // R6: gate closes during a frame; that frame ends, next waits
    @(negedge clk);
    auto_cts_en = 1'b1;
    cts_n = 1'b1;
    char_len = 2'b11;
    parity_mode = 2'b00;
    stop_long = 1'b0;
    divisor = 16'd1;
    start_pending = 0;
    push(8'hA5);
    push(8'h3C);
    cts_n = 1'b0;
    fork
      rx_frame(8, 1'b0, 16, 640, d, p, sb, stopc);
      begin
        repeat (40) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    check("R6", "frame in flight completes", d, 8'hA5);
    check("R6", "next start held off", stopc, 640);
    check("R6", "idle while held", tx_idle, 1);
    check("R6", "byte still queued", fifo_empty, 0);
    cts_n = 1'b0;
    rx_frame(8, 1'b0, 16, 48, d, p, sb, stopc);
    check("R6", "held byte sent after release", d, 8'h3C);

    for (int it = 0; it < 12; it++) begin
      run_case(2'($urandom), 2'($urandom), 1'($urandom),
               1 + int'($urandom % 3), 1 + int'($urandom % 5), 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule